// File: doc/BRIEF.md
# I/O Window Address Decoder

This block sits between a host request port and a group of peripheral register files that together fill one 128 KB I/O window. On every request it splits the offset into one of three regions: peripheral registers, per-channel DMA registers, or the interrupt register block. It then raises the select line of the one target that should answer, and works out the register index that target expects. The way the index is formed depends on the peripheral. Two slot numbers lead to one timer-style device. One slot gives a second, remapped view onto the serial controller. One slot is an internal eight-byte station-address ROM. The top six slots lead to narrow 16-bit legacy devices. For those six, the block copies the 16-bit value across byte lanes and reverses byte order to fit the access size.

Selects, the index, the write strobe and the write data follow the request combinationally, so a target can take a write in the request cycle. Read data, a read-valid flag and an error pulse come out of registers one cycle after the request. A read of anything absent returns zero and a write to it goes nowhere. The error pulse marks such accesses, and also legacy writes that are not aligned.

Top module: `mmio_region_decoder`

## Requirements
- R1: Offset bit 16 set picks the peripheral region. Bit 16 clear with bit 15 set picks DMA channel offset[11:8]: `dma_sel` is one-hot on that channel and `dma_reg` = offset[7:0]. Both bits clear raise `irq_sel` with `irq_reg` = offset[14:0]. At most one select line is high at a time.
- R2: Peripheral slots 0, 1, 3, 4, 5 and 8 (slot = offset[15:12]) assert `dev_sel[slot]` with `dev_idx` = offset[7:4], and read data is that port's `dev_rdata` word.
- R3: Slots 6 and 7 both assert `dev_sel[6]`, with `dev_idx` = offset[12:9]. `dev_sel[7]` never rises.
- R4: Slot 2 always drives `dev_sel[3]`. When offset[7:0] < 16 the index is {offset[1], offset[4:2]}; otherwise it is offset[7:4]. `dev_sel[2]` never rises.
- R5: A read of slot 9 returns byte k = offset[6:4] of the ROM parameter (bits 8k+7:8k), zero-extended, and selects no port. A write to slot 9 selects nothing and pulses the error output.
- R6: A legacy read (slots 10–15, present) takes the port's low 16 bits v and forms byte stream b[i] = v[7:0] for i mod 4 = 0, v[15:8] for i mod 4 = 1, else 0. With lane L = offset[1:0], size 1 gives b[L]; size 2 gives {b[L], b[L+1]}; size 4 gives {b[L], b[L+1], b[L+2], b[L+3]} (first byte most significant). Any other size gives 0.
- R7: A legacy access selects `dev_sel[slot]` with `dev_idx` = offset[8:4]. On a write, `bus_wdata` is {24'h0, w[7:0]} for size 1, {16'h0, w[7:0], w[15:8]} for sizes 2 and 4, and 0 for any other size.
- R8: A legacy write with offset[3:0] ≠ 0 still goes to the device, and the error output pulses.
- R9: An absent legacy slot (LEG_PRESENT bit clear; default: slots 11, 12 and 14 absent) and an unimplemented DMA channel (DMA_PRESENT bit clear; default: only 0–4 and 10 present) get no select and no write strobe. A read of either returns 0, and either access pulses the error output.
- R10: `rsp_valid`, `rsp_rdata` and `err_pulse` change in the cycle after the request. `rsp_valid` is high only after reads, and `rsp_rdata` is zero whenever `rsp_valid` is low. With no request, no select is high and no error pulses.
- R11: During synchronous active-low reset, `rsp_valid`, `rsp_rdata` and `err_pulse` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 17 | Byte offset inside the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | Unmapped, absent or misaligned access (one cycle after) |
| dev_sel | output | 16 | One-hot peripheral port select |
| dev_idx | output | 5 | Peripheral register index |
| dev_rdata | input | 512 | Read words of the 16 peripheral ports, port p at bits 32p+31:32p |
| dma_sel | output | 16 | One-hot DMA channel select |
| dma_reg | output | 8 | DMA register offset |
| dma_rdata | input | 512 | Read words of the 16 DMA channels |
| irq_sel | output | 1 | Interrupt register block select |
| irq_reg | output | 15 | Interrupt register offset |
| irq_rdata | input | 32 | Interrupt block read word |
| bus_wdata | output | 32 | Write data to the selected target (formatted for legacy ports) |
| bus_we | output | 1 | Write strobe to the selected target |
| bus_size | output | 3 | Access size passed to the target |

## Verification
Selects, index, write data and write strobe are combinational, so they are due in the request cycle itself. The bench drives each request just after a falling edge and compares these outputs one nanosecond later, before the rising edge that ends the request. Read data, read-valid and the error pulse go through one register. For every request, the driver puts the expected values into a queue. The monitor notes at the rising edge whether a request was sampled, and at the following falling edge it pops the queue and compares. Cycles with no request are checked to be quiet at that same point.

// File: rtl/mmio_dec_pkg.sv
// Shared types and helpers for the I/O window decoder.
// Assumes a 17-bit window offset and a 4-bit peripheral slot number.
package mmio_dec_pkg;

    typedef enum logic [1:0] {
        RGN_INTR = 2'd0,
        RGN_DMA  = 2'd1,
        RGN_DEV  = 2'd2
    } region_e;

    typedef struct {
        logic rd;
        logic [31:0] data;
        logic err;
    } unused_rsp_t;

    // Slot numbers whose behaviour differs from the plain index rule
    localparam int SLOT_COMPAT   = 2;
    localparam int SLOT_SERIAL   = 3;
    localparam int SLOT_TMR_LO   = 6;
    localparam int SLOT_TMR_HI   = 7;
    localparam int SLOT_ROM      = 9;
    localparam int SLOT_LEG_BASE = 10;

    // Reverse the two bytes of a halfword
    function automatic logic [15:0] swap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    // Reverse the four bytes of a word
    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    // Remap of the compatibility serial view: rotate the 4-bit index right
    function automatic logic [3:0] compat_remap(input logic [3:0] i);
        return {i[0], i[3:1]};
    endfunction

endpackage

// File: rtl/mmio_region_classify.sv
// Splits a request offset into region, target port and register index.
// Purely combinational; every hit/error output is gated by req_valid.
// Assumes region bits sit at the top two offset bits, slot at [15:12].
module mmio_region_classify
    import mmio_dec_pkg::*;
#(
    parameter int OFFS_W = 17,
    parameter int SUB_W  = 4,
    parameter int CHAN_W = 4,
    parameter int IDX_W  = 5,
    parameter int LEG_NUM = 6,
    parameter logic [LEG_NUM-1:0]       LEG_PRESENT = '1,
    parameter logic [(1<<CHAN_W)-1:0]   DMA_PRESENT = '1
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFFS_W-1:0] req_offset,
    output region_e           region,
    output logic [SUB_W-1:0]  port,
    output logic [IDX_W-1:0]  idx,
    output logic [CHAN_W-1:0] chan,
    output logic              port_hit,
    output logic              rom_hit,
    output logic              leg_hit,
    output logic              dma_hit,
    output logic              irq_hit,
    output logic              map_err,
    output logic              align_err
);
    localparam int DEV_BIT  = OFFS_W - 1;
    localparam int DMA_BIT  = OFFS_W - 2;
    localparam int SUB_LSB  = 12;
    localparam int CHAN_LSB = 8;
    localparam int NSLOT    = 1 << SUB_W;

    logic [SUB_W-1:0] slot;
    logic [IDX_W-1:0] idx_std, idx_tmr, idx_leg, idx_cmp;
    logic             compat_low;
    logic [NSLOT-1:0] leg_slot_map, leg_here_map;

    assign slot       = req_offset[SUB_LSB +: SUB_W];
    assign chan       = req_offset[CHAN_LSB +: CHAN_W];
    assign idx_std    = IDX_W'(req_offset[7:4]);
    assign idx_tmr    = IDX_W'(req_offset[12:9]);
    assign idx_leg    = IDX_W'(req_offset[8:4]);
    assign idx_cmp    = IDX_W'(compat_remap(req_offset[4:1]));
    assign compat_low = (req_offset[7:0] < 8'd16);

    // Per-slot tables: which slots are legacy, and which of those are fitted
    for (genvar g = 0; g < NSLOT; g++) begin : g_leg
        if (g >= SLOT_LEG_BASE && g < SLOT_LEG_BASE + LEG_NUM) begin : g_in
            assign leg_slot_map[g] = 1'b1;
            assign leg_here_map[g] = LEG_PRESENT[g - SLOT_LEG_BASE];
        end else begin : g_out
            assign leg_slot_map[g] = 1'b0;
            assign leg_here_map[g] = 1'b0;
        end
    end

    // Region from the two top offset bits, device space winning
    always_comb begin : region_pick
        if (req_offset[DEV_BIT])      region = RGN_DEV;
        else if (req_offset[DMA_BIT]) region = RGN_DMA;
        else                          region = RGN_INTR;
    end

    // Target port, index and error flags for the current request
    always_comb begin : target_pick
        port      = slot;
        idx       = idx_std;
        port_hit  = 1'b0;
        rom_hit   = 1'b0;
        leg_hit   = 1'b0;
        dma_hit   = 1'b0;
        irq_hit   = 1'b0;
        map_err   = 1'b0;
        align_err = 1'b0;
        if (req_valid) begin
            case (region)
                RGN_DEV: begin
                    if (leg_slot_map[slot]) begin
                        idx = idx_leg;
                        if (leg_here_map[slot]) begin
                            port_hit  = 1'b1;
                            leg_hit   = 1'b1;
                            align_err = req_write && (req_offset[3:0] != 4'd0);
                        end else begin
                            map_err = 1'b1;
                        end
                    end else if (slot == SUB_W'(SLOT_ROM)) begin
                        if (req_write) map_err = 1'b1;
                        else           rom_hit = 1'b1;
                    end else if (slot == SUB_W'(SLOT_TMR_LO) ||
                                 slot == SUB_W'(SLOT_TMR_HI)) begin
                        port     = SUB_W'(SLOT_TMR_LO);
                        idx      = idx_tmr;
                        port_hit = 1'b1;
                    end else if (slot == SUB_W'(SLOT_COMPAT)) begin
                        port     = SUB_W'(SLOT_SERIAL);
                        idx      = compat_low ? idx_cmp : idx_std;
                        port_hit = 1'b1;
                    end else begin
                        port_hit = 1'b1;
                    end
                end
                RGN_DMA: begin
                    if (DMA_PRESENT[chan]) dma_hit = 1'b1;
                    else                   map_err = 1'b1;
                end
                default: irq_hit = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/mmio_legacy_lane.sv
// Byte-lane and byte-order formatting for 16-bit legacy peripherals.
// Reads: the halfword is copied to lanes 0 and 4 of an 8-byte stream,
// shifted by the lane, cut to size and returned most-significant first.
// Writes: size 1 keeps the low byte, sizes 2/4 swap the low halfword.
// Assumes DATA_W = 32 and LEG_W = 16.
module mmio_legacy_lane
    import mmio_dec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEG_W  = 16
) (
    input  logic [2:0]        size,
    input  logic [1:0]        lane,
    input  logic [LEG_W-1:0]  rd16,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_fmt,
    output logic [LEG_W-1:0]  wr_fmt
);
    localparam int PAD_W = DATA_W - LEG_W;

    logic [2*DATA_W-1:0] rep;
    logic [2*DATA_W-1:0] shifted;

    assign rep     = {{PAD_W{1'b0}}, rd16, {PAD_W{1'b0}}, rd16};
    assign shifted = rep >> {lane, 3'b000};

    // Read word by access size
    always_comb begin : read_fmt
        case (size)
            3'd1:    rd_fmt = DATA_W'(shifted[7:0]);
            3'd2:    rd_fmt = DATA_W'(swap16(shifted[15:0]));
            3'd4:    rd_fmt = swap32(shifted[31:0]);
            default: rd_fmt = '0;
        endcase
    end

    // Write halfword by access size
    always_comb begin : write_fmt
        case (size)
            3'd1:       wr_fmt = LEG_W'(wdata[7:0]);
            3'd2, 3'd4: wr_fmt = swap16(wdata[15:0]);
            default:    wr_fmt = '0;
        endcase
    end

endmodule

// File: rtl/mmio_id_rom.sv
// Small read-only station-address store; byte g is ROM_DATA[8g+7:8g].
// Assumes ROM_BYTES is a power of two.
module mmio_id_rom #(
    parameter int ROM_BYTES = 8,
    parameter logic [8*ROM_BYTES-1:0] ROM_DATA = '0,
    localparam int AW = $clog2(ROM_BYTES)
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    byte_out
);
    logic [7:0] rom_byte [ROM_BYTES];

    for (genvar g = 0; g < ROM_BYTES; g++) begin : g_byte
        assign rom_byte[g] = ROM_DATA[8*g +: 8];
    end

    assign byte_out = rom_byte[addr];

endmodule

// File: rtl/mmio_region_decoder.sv
// Top of the I/O window decoder. Select, index and write path follow the
// request combinationally; read data, read-valid and error come from
// registers one cycle after the request. Absent targets read as zero.
module mmio_region_decoder
    import mmio_dec_pkg::*;
#(
    parameter int OFFS_W    = 17,
    parameter int DATA_W    = 32,
    parameter int SUB_W     = 4,
    parameter int CHAN_W    = 4,
    parameter int IDX_W     = 5,
    parameter int LEG_NUM   = 6,
    parameter int LEG_W     = 16,
    parameter int ROM_BYTES = 8,
    parameter logic [LEG_NUM-1:0]     LEG_PRESENT = 6'b101001,
    parameter logic [(1<<CHAN_W)-1:0] DMA_PRESENT = 16'h041F,
    parameter logic [8*ROM_BYTES-1:0] ROM_DATA    = 64'h3C96_E107_B428_5DF0,
    localparam int NSUB   = 1 << SUB_W,
    localparam int NCHAN  = 1 << CHAN_W,
    localparam int IRQ_W  = OFFS_W - 2,
    localparam int ROM_AW = $clog2(ROM_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [OFFS_W-1:0]       req_offset,
    input  logic [2:0]              req_size,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    err_pulse,
    output logic [NSUB-1:0]         dev_sel,
    output logic [IDX_W-1:0]        dev_idx,
    input  logic [NSUB*DATA_W-1:0]  dev_rdata,
    output logic [NCHAN-1:0]        dma_sel,
    output logic [7:0]              dma_reg,
    input  logic [NCHAN*DATA_W-1:0] dma_rdata,
    output logic                    irq_sel,
    output logic [IRQ_W-1:0]        irq_reg,
    input  logic [DATA_W-1:0]       irq_rdata,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_we,
    output logic [2:0]              bus_size
);
    region_e           c_region;
    logic [SUB_W-1:0]  c_port;
    logic [IDX_W-1:0]  c_idx;
    logic [CHAN_W-1:0] c_chan;
    logic c_port_hit, c_rom_hit, c_leg_hit, c_dma_hit, c_irq_hit;
    logic c_map_err, c_align_err;

    logic [DATA_W-1:0] dev_word [NSUB];
    logic [DATA_W-1:0] dma_word [NCHAN];
    logic [DATA_W-1:0] leg_rd;
    logic [LEG_W-1:0]  leg_wr;
    logic [7:0]        rom_byte;
    logic [DATA_W-1:0] rd_next;
    logic              is_read;

    mmio_region_classify #(
        .OFFS_W(OFFS_W), .SUB_W(SUB_W), .CHAN_W(CHAN_W), .IDX_W(IDX_W),
        .LEG_NUM(LEG_NUM), .LEG_PRESENT(LEG_PRESENT), .DMA_PRESENT(DMA_PRESENT)
    ) u_classify (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_offset(req_offset),
        .region    (c_region),
        .port      (c_port),
        .idx       (c_idx),
        .chan      (c_chan),
        .port_hit  (c_port_hit),
        .rom_hit   (c_rom_hit),
        .leg_hit   (c_leg_hit),
        .dma_hit   (c_dma_hit),
        .irq_hit   (c_irq_hit),
        .map_err   (c_map_err),
        .align_err (c_align_err)
    );

    mmio_legacy_lane #(.DATA_W(DATA_W), .LEG_W(LEG_W)) u_lane (
        .size  (req_size),
        .lane  (req_offset[1:0]),
        .rd16  (dev_word[c_port][LEG_W-1:0]),
        .wdata (req_wdata),
        .rd_fmt(leg_rd),
        .wr_fmt(leg_wr)
    );

    mmio_id_rom #(.ROM_BYTES(ROM_BYTES), .ROM_DATA(ROM_DATA)) u_rom (
        .addr    (req_offset[4 +: ROM_AW]),
        .byte_out(rom_byte)
    );

    // Unpack the flat read buses and build the one-hot selects
    for (genvar p = 0; p < NSUB; p++) begin : g_dev
        assign dev_word[p] = dev_rdata[p*DATA_W +: DATA_W];
        assign dev_sel[p]  = c_port_hit && (c_port == SUB_W'(p));
    end
    for (genvar c = 0; c < NCHAN; c++) begin : g_dma
        assign dma_word[c] = dma_rdata[c*DATA_W +: DATA_W];
        assign dma_sel[c]  = c_dma_hit && (c_chan == CHAN_W'(c));
    end

    assign irq_sel   = c_irq_hit;
    assign dev_idx   = c_idx;
    assign dma_reg   = req_offset[7:0];
    assign irq_reg   = req_offset[IRQ_W-1:0];
    assign bus_size  = req_size;
    assign bus_we    = req_valid && req_write && (c_port_hit || c_dma_hit || c_irq_hit);
    assign bus_wdata = c_leg_hit ? DATA_W'(leg_wr) : req_wdata;
    assign is_read   = req_valid && !req_write;

    // Choose the word a read returns; anything unmatched reads zero
    always_comb begin : read_mux
        rd_next = '0;
        if (c_leg_hit)       rd_next = leg_rd;
        else if (c_port_hit) rd_next = dev_word[c_port];
        else if (c_rom_hit)  rd_next = DATA_W'(rom_byte);
        else if (c_dma_hit)  rd_next = dma_word[c_chan];
        else if (c_irq_hit)  rd_next = irq_rdata;
    end

    // Response register: one cycle after the request
    always_ff @(posedge clk) begin : rsp_reg
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_pulse <= 1'b0;
        end else begin
            rsp_valid <= is_read;
            rsp_rdata <= is_read ? rd_next : '0;
            err_pulse <= c_map_err || c_align_err;
        end
    end

endmodule

// File: rtl/mmio_region_decoder_chk.sv
// Protocol checker for the I/O window decoder, attached by bind below.
// Observes ports only; assumes the default slot layout of the decoder.
module mmio_region_decoder_chk #(
    parameter int OFFS_W  = 17,
    parameter int NSUB    = 16,
    parameter int NCHAN   = 16,
    parameter int DATA_W  = 32,
    parameter int LEG_NUM = 6,
    parameter logic [LEG_NUM-1:0] LEG_PRESENT = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [OFFS_W-1:0] req_offset,
    input logic [NSUB-1:0]   dev_sel,
    input logic [NCHAN-1:0]  dma_sel,
    input logic              irq_sel,
    input logic [7:0]        dma_reg,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              err_pulse
);
    localparam int LEG_BASE = 10;

    logic [NSUB-1:0] absent_map;
    logic            dev_space;
    logic [3:0]      slot;

    assign dev_space = req_offset[OFFS_W-1];
    assign slot      = req_offset[15:12];

    // Slots that are legacy but not fitted
    for (genvar g = 0; g < NSUB; g++) begin : g_abs
        if (g >= LEG_BASE && g < LEG_BASE + LEG_NUM) begin : g_in
            assign absent_map[g] = !LEG_PRESENT[g - LEG_BASE];
        end else begin : g_out
            assign absent_map[g] = 1'b0;
        end
    end

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_sel, dma_sel, irq_sel})); // R1
    AST_DMA_REG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_sel) |-> (dma_reg == req_offset[7:0])); // R1
    AST_TIMER_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_sel[7]); // R3
    AST_NO_COMPAT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_sel[2]); // R4
    AST_ROM_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_sel[9]); // R5
    AST_ROM_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && dev_space && slot == 4'd9) |=> err_pulse); // R5
    AST_ABSENT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dev_space && absent_map[slot]) |=> err_pulse); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (dev_sel == '0 && dma_sel == '0 && !irq_sel)); // R10
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R10
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R10
    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !err_pulse); // R10
    AST_RDATA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0)); // R10

endmodule

bind mmio_region_decoder mmio_region_decoder_chk #(
    .OFFS_W(OFFS_W), .NSUB(NSUB), .NCHAN(NCHAN), .DATA_W(DATA_W),
    .LEG_NUM(LEG_NUM), .LEG_PRESENT(LEG_PRESENT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_offset(req_offset),
    .dev_sel   (dev_sel),
    .dma_sel   (dma_sel),
    .irq_sel   (irq_sel),
    .dma_reg   (dma_reg),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .err_pulse (err_pulse)
);

// File: tb/tb_mmio_region_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected responses, the monitor
// pops them one cycle after each request and compares.
module tb_mmio_region_decoder;

    typedef struct {
        bit          rd;
        logic [31:0] data;
        bit          err;
        string       tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [16:0]  req_offset = '0;
    logic [2:0]   req_size = 3'd4;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         err_pulse;
    logic [15:0]  dev_sel;
    logic [4:0]   dev_idx;
    logic [511:0] dev_rdata;
    logic [15:0]  dma_sel;
    logic [7:0]   dma_reg;
    logic [511:0] dma_rdata;
    logic         irq_sel;
    logic [14:0]  irq_reg;
    logic [31:0]  irq_rdata = 32'h1E2D_3C4B;
    logic [31:0]  bus_wdata;
    logic         bus_we;
    logic [2:0]   bus_size;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    localparam logic [63:0] ROM_IMG = 64'h3C96_E107_B428_5DF0;

    always #2 clk = ~clk;

    function automatic logic [31:0] dev_pat(input int p);
        return {16'hC0DE, 4'(p), 12'hA5B};
    endfunction

    for (genvar p = 0; p < 16; p++) begin : g_src
        assign dev_rdata[p*32 +: 32] = dev_pat(p);
        assign dma_rdata[p*32 +: 32] = 32'hD0A0_0000 | p;
    end

    mmio_region_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse),
        .dev_sel(dev_sel), .dev_idx(dev_idx), .dev_rdata(dev_rdata),
        .dma_sel(dma_sel), .dma_reg(dma_reg), .dma_rdata(dma_rdata),
        .irq_sel(irq_sel), .irq_reg(irq_reg), .irq_rdata(irq_rdata),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_size(bus_size)
    );

    // Expected legacy read word, built from the byte-stream rule of R6
    function automatic logic [31:0] leg_exp(input logic [15:0] v, input int lane, input int sz);
        logic [7:0] b [8];
        logic [31:0] r;
        for (int i = 0; i < 8; i++) begin
            b[i] = (i % 4 == 0) ? v[7:0] : (i % 4 == 1) ? v[15:8] : 8'h00;
        end
        case (sz)
            1:       r = {24'h0, b[lane]};
            2:       r = {16'h0, b[lane], b[lane+1]};
            4:       r = {b[lane], b[lane+1], b[lane+2], b[lane+3]};
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request after a falling edge and queue its expected response
    task automatic issue(input bit w, input logic [16:0] off, input logic [2:0] sz,
                         input logic [31:0] wd, input logic [31:0] erd,
                         input bit eerr, input string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = w;
        req_offset = off;
        req_size   = sz;
        req_wdata  = wd;
        exp_q.push_back('{rd: !w, data: erd, err: eerr, tag: tag});
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: registered results are due at the falling edge after the request
    initial begin : monitor
        exp_t e;
        bit   had;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            had = req_valid;
            @(negedge clk);
            if (had && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk({e.tag, " rsp_valid (R10)"}, {31'h0, rsp_valid}, {31'h0, e.rd});
                chk({e.tag, " rdata"}, rsp_rdata, e.rd ? e.data : 32'h0);
                chk({e.tag, " err_pulse"}, {31'h0, err_pulse}, {31'h0, e.err});
            end else begin
                chk("R10 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
                chk("R10 idle err_pulse", {31'h0, err_pulse}, 32'h0);
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R11 reset rsp_rdata", rsp_rdata, 32'h0);
        chk("R11 reset err_pulse", {31'h0, err_pulse}, 32'h0);
        rst_n = 1'b1;

        // R2 plain slots
        issue(0, 17'h10050, 3'd4, 0, dev_pat(0), 0, "R2 slot0");
        chk("R2 slot0 sel", {16'h0, dev_sel}, 32'h0001);
        chk("R2 slot0 idx", {27'h0, dev_idx}, 32'h5);
        issue(0, 17'h180F0, 3'd4, 0, dev_pat(8), 0, "R2 slot8");
        chk("R2 slot8 sel", {16'h0, dev_sel}, 32'h0100);
        chk("R2 slot8 idx", {27'h0, dev_idx}, 32'hF);

        // R3 merged timer slots
        issue(0, 17'h16E00, 3'd4, 0, dev_pat(6), 0, "R3 slot6");
        chk("R3 slot6 sel", {16'h0, dev_sel}, 32'h0040);
        chk("R3 slot6 idx", {27'h0, dev_idx}, 32'h7);
        issue(0, 17'h17400, 3'd4, 0, dev_pat(6), 0, "R3 slot7");
        chk("R3 slot7 sel", {16'h0, dev_sel}, 32'h0040);
        chk("R3 slot7 idx", {27'h0, dev_idx}, 32'hA);

        // R4 compatibility serial view
        issue(0, 17'h1200A, 3'd1, 0, dev_pat(3), 0, "R4 compat low");
        chk("R4 compat low sel", {16'h0, dev_sel}, 32'h0008);
        chk("R4 compat low idx", {27'h0, dev_idx}, 32'hA);
        issue(0, 17'h12030, 3'd1, 0, dev_pat(3), 0, "R4 compat high");
        chk("R4 compat high sel", {16'h0, dev_sel}, 32'h0008);
        chk("R4 compat high idx", {27'h0, dev_idx}, 32'h3);
        issue(1, 17'h12006, 3'd1, 32'h55, 0, 0, "R4 compat write");
        chk("R4 compat write idx", {27'h0, dev_idx}, 32'h9);
        chk("R4 compat write we", {31'h0, bus_we}, 32'h1);

        // R5 station-address ROM
        issue(0, 17'h19030, 3'd4, 0, {24'h0, ROM_IMG[31:24]}, 0, "R5 rom byte3");
        chk("R5 rom sel", {16'h0, dev_sel}, 32'h0);
        issue(0, 17'h19070, 3'd1, 0, {24'h0, ROM_IMG[63:56]}, 0, "R5 rom byte7");
        issue(1, 17'h19000, 3'd1, 32'hFF, 0, 1, "R5 rom write");
        chk("R5 rom write we", {31'h0, bus_we}, 32'h0);

        // R6 legacy reads on slot 13 and 15
        issue(0, 17'h1D1A0, 3'd4, 0, leg_exp(16'hDA5B, 0, 4), 0, "R6 lane0 sz4");
        chk("R7 legacy read sel", {16'h0, dev_sel}, 32'h2000);
        chk("R7 legacy read idx", {27'h0, dev_idx}, 32'h1A);
        issue(0, 17'h1D1A1, 3'd2, 0, leg_exp(16'hDA5B, 1, 2), 0, "R6 lane1 sz2");
        issue(0, 17'h1D1A3, 3'd1, 0, leg_exp(16'hDA5B, 3, 1), 0, "R6 lane3 sz1");
        issue(0, 17'h1D1A2, 3'd4, 0, leg_exp(16'hDA5B, 2, 4), 0, "R6 lane2 sz4");
        issue(0, 17'h1D1A0, 3'd1, 0, leg_exp(16'hDA5B, 0, 1), 0, "R6 lane0 sz1");
        issue(0, 17'h1F000, 3'd2, 0, leg_exp(16'hFA5B, 0, 2), 0, "R6 slot15 sz2");
        issue(0, 17'h1F000, 3'd3, 0, 32'h0, 0, "R6 bad size");

        // R7 legacy writes
        issue(1, 17'h1F0C0, 3'd2, 32'h0000_1234, 0, 0, "R7 write sz2");
        chk("R7 write sz2 data", bus_wdata, 32'h3412);
        chk("R7 write sz2 idx", {27'h0, dev_idx}, 32'h0C);
        chk("R7 write sz2 sel", {16'h0, dev_sel}, 32'h8000);
        issue(1, 17'h1F0C0, 3'd1, 32'h0000_ABCD, 0, 0, "R7 write sz1");
        chk("R7 write sz1 data", bus_wdata, 32'h00CD);
        issue(1, 17'h1A0C0, 3'd4, 32'hCAFE_BEEF, 0, 0, "R7 write sz4");
        chk("R7 write sz4 data", bus_wdata, 32'hEFBE);
        chk("R7 write sz4 sel", {16'h0, dev_sel}, 32'h0400);

        // R8 misaligned legacy write still delivered
        issue(1, 17'h1F0C2, 3'd2, 32'h0000_5678, 0, 1, "R8 misaligned");
        chk("R8 misaligned sel", {16'h0, dev_sel}, 32'h8000);
        chk("R8 misaligned we", {31'h0, bus_we}, 32'h1);

        // R9 absent legacy slots and unimplemented DMA channel
        issue(0, 17'h1B010, 3'd2, 0, 32'h0, 1, "R9 absent read");
        chk("R9 absent read sel", {16'h0, dev_sel}, 32'h0);
        issue(1, 17'h1E000, 3'd1, 32'h12, 0, 1, "R9 absent write");
        chk("R9 absent write we", {31'h0, bus_we}, 32'h0);
        issue(0, 17'h0870C, 3'd4, 0, 32'h0, 1, "R9 dma absent");
        chk("R9 dma absent sel", {16'h0, dma_sel}, 32'h0);

        // R1 DMA and interrupt regions
        issue(0, 17'h0823C, 3'd4, 0, 32'hD0A0_0002, 0, "R1 dma read");
        chk("R1 dma sel", {16'h0, dma_sel}, 32'h0004);
        chk("R1 dma reg", {24'h0, dma_reg}, 32'h3C);
        chk("R1 dma no dev", {16'h0, dev_sel}, 32'h0);
        issue(1, 17'h08A10, 3'd4, 32'h77, 0, 0, "R1 dma write");
        chk("R1 dma write sel", {16'h0, dma_sel}, 32'h0400);
        chk("R1 dma write data", bus_wdata, 32'h77);
        issue(0, 17'h04024, 3'd4, 0, 32'h1E2D_3C4B, 0, "R1 irq read");
        chk("R1 irq sel", {31'h0, irq_sel}, 32'h1);
        chk("R1 irq reg", {17'h0, irq_reg}, 32'h4024);
        issue(1, 17'h00028, 3'd4, 32'h8000_0001, 0, 0, "R1 irq write");
        chk("R1 irq write we", {31'h0, bus_we}, 32'h1);

        // R10 idle cycles: no selects
        idle();
        chk("R10 idle dev_sel", {16'h0, dev_sel}, 32'h0);
        chk("R10 idle irq_sel", {31'h0, irq_sel}, 32'h0);
        repeat (4) idle();

        summary();
        $finish;
    end

endmodule